// File: doc/BRIEF.md
# Flash Status Register and Write-Protect Controller

This block owns the 8-bit status register of a serial flash device and decides, for every write-type request, whether it may proceed. A serial front end (not part of this block) decodes opcodes and hands over single-cycle command strobes, the received data byte and the 19-bit target address. The block then sets or clears the write-enable latch, stages and commits status register writes, applies the write-protect pin rules, and checks each program or erase target against the block-protect level.

Accepted program and erase requests start a self-timed busy period whose length is a parameter in clock cycles. At its start the memory array receives a one-cycle strobe. For erases, this strobe comes with an address window: an inclusive low bound and an exclusive high bound. While any internal write runs, the status byte reads back as all ones. Every other command strobe is then dropped. The write-enable latch clears itself when each write cycle completes.

Top module: `wp_status_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `busy` is 0, `wr_allow` is 0 and no strobe is issued.
- R2: When idle, the status byte is {WPEN, BP4..BP0, WEN, RDY}, with bit 7 WPEN, bits 6:2 BP4..BP0, bit 1 WEN and bit 0 RDY=0. While `busy` is 1 the status byte reads FFh.
- R3: `cmd_wren` sets WEN. `cmd_wrdi` clears WEN whatever the level of `wp_n`.
- R4: A status write (`cmd_wrsr` with WEN=1) latches `din[7:2]` and waits. The busy period starts at the first clock edge that samples `cs_n` high and lasts exactly SR_CYC cycles. At its end, status bits 7:2 take the latched value and WEN clears. Without WEN the strobe is ignored.
- R5: Hardware protection is active when `wp_n`=0 and WPEN=1. It rejects a status write strobe outright. If it becomes active while a status write waits for `cs_n`, the write is cancelled, even when `cs_n` rises in that same cycle. The status byte stays unchanged and WEN stays as it was.
- R6: Protect level is BP2..BP0 (status bits 4:2). Level 0 locks nothing. Level L from 1 to 6 locks the top 1/2^(7-L) of the 512 KiB array, i.e. from 7E000h, 7C000h, 78000h, 70000h, 60000h or 40000h up to 7FFFFh. Level 7 locks everything. BP4 and BP3 are stored but have no effect on locking.
- R7: `wr_allow` is 1 exactly when the controller is idle, WEN=1 and `addr` is not locked.
- R8: `cmd_prog` while `wr_allow`=1 gives a one-cycle `prog_go` and a busy period of PROG_CYC cycles, after which WEN is 0. Otherwise it is ignored.
- R9: A sector erase with WEN=1 aligns `addr` down to 4 KiB and gives `erase_go` with `erase_lo` = the aligned base and `erase_hi` = base+1000h. The busy period lasts SEC_CYC cycles and WEN clears afterwards. The request is skipped if any part of the sector is locked.
- R10: A block erase behaves the same way with a 64 KiB window (+10000h) and BLK_CYC cycles.
- R11: A chip erase with WEN=1 gives `erase_lo`=0 and `erase_hi` = the first locked address (80000h at level 0), with CHIP_CYC cycles. At level 7 it is skipped.
- R12: While busy, or while a status write waits for `cs_n`, all command strobes are dropped and have no later effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select level from the serial pins (high = deselected) |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_wren | input | 1 | Set-write-enable strobe |
| cmd_wrdi | input | 1 | Clear-write-enable strobe |
| cmd_wrsr | input | 1 | Status write strobe (data in `din`) |
| cmd_prog | input | 1 | Program request strobe for `addr` |
| cmd_sec_erase | input | 1 | 4 KiB erase request strobe |
| cmd_blk_erase | input | 1 | 64 KiB erase request strobe |
| cmd_chip_erase | input | 1 | Whole-array erase request strobe |
| din | input | 8 | Data byte for status writes |
| addr | input | 19 | Target byte address |
| status | output | 8 | Status byte |
| busy | output | 1 | Internal write cycle in progress |
| wr_allow | output | 1 | Write to `addr` would be accepted now |
| prog_go | output | 1 | One-cycle program start to the array |
| erase_go | output | 1 | One-cycle erase start to the array |
| erase_lo | output | 19 | First address of the erase window |
| erase_hi | output | 20 | Exclusive end of the erase window |

## Verification
Two functions can meet in a single cycle while a status write is pending: the commit trigger from `cs_n` going high, and the cancel from the write-protect pin going low with WPEN set. The bench provokes this by raising `cs_n` and lowering `wp_n` on the same falling edge. It then requires that no busy period follows and that the status byte is unchanged. The bench also sends command strobes in the middle of erase cycles and checks afterwards that WEN was never set by them. Random protect levels, addresses and erase kinds are compared with a bench model of the protect ladder and the erase windows.

// File: rtl/wpsc_pkg.sv
package wpsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SR_ARM,
        ST_SR_BUSY,
        ST_PROG_BUSY,
        ST_ERASE_BUSY
    } wpsc_state_e;

    typedef enum logic [1:0] {
        ER_SECT,
        ER_BLK,
        ER_CHIP
    } er_kind_e;

    localparam int LADDER_STEPS = 6;

endpackage

// File: rtl/wpsc_prot_map.sv
module wpsc_prot_map #(
    parameter int ADDR_W = 19
) (
    input  logic [2:0]        level,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked,
    output logic [ADDR_W:0]   lock_base
);
    import wpsc_pkg::*;

    localparam logic [ADDR_W:0] FULL = (ADDR_W+1)'(1) << ADDR_W;

    logic [LADDER_STEPS:1] hit;
    logic [ADDR_W:0]       base_at [LADDER_STEPS:1];

    // Step j locks the top fraction 1/2^(7-j): those top address bits all ones.
    generate
        for (genvar j = 1; j <= LADDER_STEPS; j++) begin : g_step
            localparam int TOPB = LADDER_STEPS + 1 - j;
            assign hit[j]     = &addr[ADDR_W-1 -: TOPB];
            assign base_at[j] = FULL - ((ADDR_W+1)'(1) << (ADDR_W - TOPB));
        end
    endgenerate

    always_comb begin
        locked    = 1'b0;
        lock_base = FULL;
        if (level == 3'd7) begin
            locked    = 1'b1;
            lock_base = '0;
        end else begin
            for (int j = 1; j <= LADDER_STEPS; j++) begin
                if (level == 3'(j)) begin
                    locked    = hit[j];
                    lock_base = base_at[j];
                end
            end
        end
    end

endmodule

// File: rtl/wpsc_erase_region.sv
module wpsc_erase_region #(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 12,
    parameter int BLK_W  = 16
) (
    input  wpsc_pkg::er_kind_e kind,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W:0]    lock_base,
    output logic [ADDR_W-1:0]  lo,
    output logic [ADDR_W:0]    hi,
    output logic               skip
);
    import wpsc_pkg::*;

    localparam logic [ADDR_W:0] SECT_SPAN = (ADDR_W+1)'(1) << SECT_W;
    localparam logic [ADDR_W:0] BLK_SPAN  = (ADDR_W+1)'(1) << BLK_W;

    always_comb begin
        unique case (kind)
            ER_SECT: begin
                lo   = {addr[ADDR_W-1:SECT_W], SECT_W'(0)};
                hi   = {1'b0, lo} + SECT_SPAN;
                skip = hi > lock_base;
            end
            ER_BLK: begin
                lo   = {addr[ADDR_W-1:BLK_W], BLK_W'(0)};
                hi   = {1'b0, lo} + BLK_SPAN;
                skip = hi > lock_base;
            end
            ER_CHIP: begin
                lo   = '0;
                hi   = lock_base;
                skip = (lock_base == '0);
            end
            default: begin
                lo   = '0;
                hi   = '0;
                skip = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wpsc_busy_timer.sv
module wpsc_busy_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/wp_status_ctrl.sv
module wp_status_ctrl #(
    parameter int ADDR_W   = 19,
    parameter int SECT_W   = 12,
    parameter int BLK_W    = 16,
    parameter int SR_CYC   = 6,
    parameter int PROG_CYC = 4,
    parameter int SEC_CYC  = 10,
    parameter int BLK_CYC  = 14,
    parameter int CHIP_CYC = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrdi,
    input  logic              cmd_wrsr,
    input  logic              cmd_prog,
    input  logic              cmd_sec_erase,
    input  logic              cmd_blk_erase,
    input  logic              cmd_chip_erase,
    input  logic [7:0]        din,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        status,
    output logic              busy,
    output logic              wr_allow,
    output logic              prog_go,
    output logic              erase_go,
    output logic [ADDR_W-1:0] erase_lo,
    output logic [ADDR_W:0]   erase_hi
);
    import wpsc_pkg::*;

    localparam int MAX_A   = (SR_CYC > PROG_CYC) ? SR_CYC : PROG_CYC;
    localparam int MAX_B   = (SEC_CYC > BLK_CYC) ? SEC_CYC : BLK_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > CHIP_CYC) ? MAX_C : CHIP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wpsc_state_e       state_q, state_d;
    logic              wpen_q, wen_q;
    logic [4:0]        bp_q;
    logic [5:0]        pend_q;
    logic              prog_go_q, erase_go_q;
    logic [ADDR_W-1:0] erase_lo_q;
    logic [ADDR_W:0]   erase_hi_q;

    logic              hw_prot, addr_locked, er_skip, erase_req;
    logic [ADDR_W:0]   lock_base, er_hi;
    logic [ADDR_W-1:0] er_lo;
    er_kind_e          er_kind;
    logic              take_wrsr, take_prog, take_erase;
    logic              tmr_load, tmr_done;
    logic [CNT_W-1:0]  tmr_val;

    assign hw_prot = !wp_n && wpen_q;

    wpsc_prot_map #(.ADDR_W(ADDR_W)) u_map (
        .level     (bp_q[2:0]),
        .addr      (addr),
        .locked    (addr_locked),
        .lock_base (lock_base)
    );

    always_comb begin
        if (cmd_chip_erase)     er_kind = ER_CHIP;
        else if (cmd_blk_erase) er_kind = ER_BLK;
        else                    er_kind = ER_SECT;
    end

    assign erase_req = cmd_sec_erase || cmd_blk_erase || cmd_chip_erase;

    wpsc_erase_region #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .BLK_W(BLK_W)) u_region (
        .kind      (er_kind),
        .addr      (addr),
        .lock_base (lock_base),
        .lo        (er_lo),
        .hi        (er_hi),
        .skip      (er_skip)
    );

    // Command acceptance in idle; priority WRDI, WREN, WRSR, program, erase.
    always_comb begin
        take_wrsr  = 1'b0;
        take_prog  = 1'b0;
        take_erase = 1'b0;
        if (state_q == ST_IDLE && !cmd_wrdi && !cmd_wren) begin
            if (cmd_wrsr)
                take_wrsr = wen_q && !hw_prot;
            else if (cmd_prog)
                take_prog = wen_q && !addr_locked;
            else if (erase_req)
                take_erase = wen_q && !er_skip;
        end
    end

    // Next-state logic and timer loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_wrsr) begin
                    state_d = ST_SR_ARM;
                end else if (take_prog) begin
                    state_d  = ST_PROG_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(PROG_CYC - 1);
                end else if (take_erase) begin
                    state_d  = ST_ERASE_BUSY;
                    tmr_load = 1'b1;
                    unique case (er_kind)
                        ER_CHIP: tmr_val = CNT_W'(CHIP_CYC - 1);
                        ER_BLK:  tmr_val = CNT_W'(BLK_CYC - 1);
                        default: tmr_val = CNT_W'(SEC_CYC - 1);
                    endcase
                end
            end
            ST_SR_ARM: begin
                if (hw_prot) begin
                    state_d = ST_IDLE;
                end else if (cs_n) begin
                    state_d  = ST_SR_BUSY;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(SR_CYC - 1);
                end
            end
            ST_SR_BUSY, ST_PROG_BUSY, ST_ERASE_BUSY: begin
                if (tmr_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    wpsc_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .run      (busy),
        .done     (tmr_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Register contents and array strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wpen_q     <= 1'b0;
            bp_q       <= '0;
            wen_q      <= 1'b0;
            pend_q     <= '0;
            prog_go_q  <= 1'b0;
            erase_go_q <= 1'b0;
            erase_lo_q <= '0;
            erase_hi_q <= '0;
        end else begin
            prog_go_q  <= 1'b0;
            erase_go_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_wrdi)       wen_q <= 1'b0;
                    else if (cmd_wren)  wen_q <= 1'b1;
                    if (take_wrsr)      pend_q <= din[7:2];
                    if (take_prog)      prog_go_q <= 1'b1;
                    if (take_erase) begin
                        erase_go_q <= 1'b1;
                        erase_lo_q <= er_lo;
                        erase_hi_q <= er_hi;
                    end
                end
                ST_SR_BUSY: begin
                    if (tmr_done) begin
                        {wpen_q, bp_q} <= pend_q;
                        wen_q          <= 1'b0;
                    end
                end
                ST_PROG_BUSY, ST_ERASE_BUSY: begin
                    if (tmr_done) wen_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q == ST_SR_BUSY) || (state_q == ST_PROG_BUSY) ||
                   (state_q == ST_ERASE_BUSY);
        status   = busy ? 8'hFF : {wpen_q, bp_q, wen_q, 1'b0};
        wr_allow = (state_q == ST_IDLE) && wen_q && !addr_locked;
        prog_go  = prog_go_q;
        erase_go = erase_go_q;
        erase_lo = erase_lo_q;
        erase_hi = erase_hi_q;
    end

endmodule

// File: rtl/wp_status_ctrl_checker.sv
module wp_status_ctrl_checker #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic [7:0]        status,
    input logic              busy,
    input logic              wr_allow,
    input logic              prog_go,
    input logic              erase_go,
    input logic [ADDR_W-1:0] erase_lo,
    input logic [ADDR_W:0]   erase_hi
);
    AST_BUSY_READS_FF: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> status == 8'hFF); // R2
    AST_IDLE_RDY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !status[0]); // R2
    AST_NO_ALLOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_allow); // R7
    AST_PROG_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> busy && !erase_go); // R8
    AST_ERASE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> busy && ({1'b0, erase_lo} < erase_hi)); // R9
    AST_WEN_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !status[1]); // R4
    AST_WPEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && status[7] && !busy) |=> (busy || status[7])); // R5
endmodule

bind wp_status_ctrl wp_status_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wp_n     (wp_n),
    .status   (status),
    .busy     (busy),
    .wr_allow (wr_allow),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .erase_lo (erase_lo),
    .erase_hi (erase_hi)
);

// File: tb/wp_status_ctrl_test.sv
`timescale 1ns/1ps
module wp_status_ctrl_test;
    localparam int AW = 19;
    localparam int SR_CYC = 6, PROG_CYC = 4, SEC_CYC = 10, BLK_CYC = 14, CHIP_CYC = 20;
    localparam int C_WREN = 0, C_WRDI = 1, C_WRSR = 2, C_PROG = 3,
                   C_SEC = 4, C_BLK = 5, C_CHIP = 6;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, wp_n = 1'b1;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_prog = 0;
    logic cmd_sec_erase = 0, cmd_blk_erase = 0, cmd_chip_erase = 0;
    logic [7:0] din = '0;
    logic [AW-1:0] addr = '0;
    logic [7:0] status;
    logic busy, wr_allow, prog_go, erase_go;
    logic [AW-1:0] erase_lo;
    logic [AW:0] erase_hi;

    int checks = 0, fails = 0;
    bit finished = 0;
    bit m_wpen = 0, m_wen = 0;
    logic [4:0] m_bp = '0;

    always #2.5 clk = ~clk;

    wp_status_ctrl uut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit m_locked(input int lvl, input logic [AW-1:0] a);
        int k;
        if (lvl == 0) return 1'b0;
        if (lvl == 7) return 1'b1;
        k = 7 - lvl;
        return (int'(a) >> (AW - k)) == ((1 << k) - 1);
    endfunction

    function automatic int m_base(input int lvl);
        if (lvl == 0) return 1 << AW;
        if (lvl == 7) return 0;
        return (1 << AW) - (1 << (AW - (7 - lvl)));
    endfunction

    function automatic logic [7:0] m_status();
        return {m_wpen, m_bp, m_wen, 1'b0};
    endfunction

    task automatic pulse(input int c);
        @(negedge clk);
        case (c)
            C_WREN: cmd_wren = 1;
            C_WRDI: cmd_wrdi = 1;
            C_WRSR: cmd_wrsr = 1;
            C_PROG: cmd_prog = 1;
            C_SEC:  cmd_sec_erase = 1;
            C_BLK:  cmd_blk_erase = 1;
            default: cmd_chip_erase = 1;
        endcase
        @(negedge clk);
        {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog} = '0;
        {cmd_sec_erase, cmd_blk_erase, cmd_chip_erase} = '0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_wren();
        pulse(C_WREN);
        if (!busy) m_wen = 1;
    endtask

    task automatic do_wrsr(input logic [7:0] d, input string req);
        int n;
        bit acc;
        acc = m_wen && !(!wp_n && m_wpen);
        din = d;
        cs_n = 0;
        pulse(C_WRSR);
        check(!busy, req, busy, 0);
        cs_n = 1;
        @(negedge clk);
        count_busy(n);
        if (acc) begin
            check(n == SR_CYC, req, n, SR_CYC);
            {m_wpen, m_bp} = d[7:2];
            m_wen = 0;
        end else begin
            check(n == 0, req, n, 0);
        end
        check(status == m_status(), req, status, m_status());
    endtask

    task automatic do_erase(input int c, input logic [AW-1:0] a, input string req);
        int lvl, base, lo, hi, cyc, n;
        bit skip;
        lvl = int'(m_bp[2:0]);
        base = m_base(lvl);
        if (c == C_CHIP) begin
            lo = 0; hi = base; skip = (base == 0); cyc = CHIP_CYC;
        end else if (c == C_BLK) begin
            lo = int'(a) & ~32'hFFFF; hi = lo + 32'h10000; skip = hi > base; cyc = BLK_CYC;
        end else begin
            lo = int'(a) & ~32'hFFF; hi = lo + 32'h1000; skip = hi > base; cyc = SEC_CYC;
        end
        addr = a;
        pulse(c);
        check(erase_go == (m_wen && !skip), req, erase_go, m_wen && !skip);
        if (m_wen && !skip) begin
            check(int'(erase_lo) == lo && int'(erase_hi) == hi, req,
                  {erase_lo, 20'(erase_hi)}, {19'(lo), 20'(hi)});
            count_busy(n);
            check(n == cyc, req, n, cyc);
            m_wen = 0;
        end else begin
            check(!busy, req, busy, 0);
        end
        check(status == m_status(), req, status, m_status());
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input string req);
        int n;
        bit exp;
        addr = a;
        @(negedge clk);
        exp = m_wen && !m_locked(int'(m_bp[2:0]), a);
        check(wr_allow == exp, "R7 allow", wr_allow, exp);
        pulse(C_PROG);
        check(prog_go == exp, req, prog_go, exp);
        count_busy(n);
        check(n == (exp ? PROG_CYC : 0), req, n, exp ? PROG_CYC : 0);
        if (exp) m_wen = 0;
        check(status == m_status(), req, status, m_status());
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check(status == 8'h00 && !busy && !wr_allow && !prog_go && !erase_go,
              "R1 reset", {status, busy, wr_allow}, 0);

        // R3 write enable latch
        do_wren();
        check(status == 8'h02, "R3 wren", status, 8'h02);
        wp_n = 0;
        pulse(C_WRDI); m_wen = 0;
        check(status == 8'h00, "R3 wrdi with wp low", status, 8'h00);
        wp_n = 1;

        // R4 status write without WEN is ignored
        do_wrsr(8'h1C, "R4 no wen");
        // R4 accepted status write with layout check (R2)
        do_wren();
        do_wrsr(8'h0C, "R4 commit");
        check(status == 8'h0C, "R2 layout level3", status, 8'h0C);
        // R4 commit waits for cs_n high
        do_wren();
        din = 8'h00; cs_n = 0;
        pulse(C_WRSR);
        repeat (5) @(negedge clk);
        check(!busy && status == 8'h0E, "R4 waits for cs", status, 8'h0E);
        cs_n = 1; @(negedge clk);
        count_busy(n);
        check(n == SR_CYC, "R4 busy length", n, SR_CYC);
        m_bp = '0; m_wen = 0;
        check(status == 8'h00, "R4 cleared", status, 8'h00);

        // R6 BP4/BP3 no effect on locking
        do_wren();
        do_wrsr(8'h60, "R6 bp43 write");
        do_wren();
        do_prog(19'h7FFFF, "R6 bp43 no lock");

        // R5 hardware protection
        do_wren();
        do_wrsr(8'h80, "R5 set wpen");
        do_wren();
        din = 8'h00; cs_n = 0;
        pulse(C_WRSR);
        wp_n = 0; cs_n = 1;       // cancel and commit trigger in the same cycle
        @(negedge clk);
        count_busy(n);
        check(n == 0 && status == 8'h82, "R5 abort same cycle", status, 8'h82);
        do_wrsr(8'h00, "R5 reject while protected");
        check(status == 8'h82, "R5 wpen kept", status, 8'h82);
        wp_n = 1;
        do_wrsr(8'h00, "R5 unprotected clear");
        check(status == 8'h00, "R5 wpen cleared", status, 8'h00);

        // R8 program
        do_prog(19'h12345, "R8 no wen");
        do_wren();
        do_prog(19'h12345, "R8 program");
        do_wren();
        do_wrsr(8'h1C, "R6 level7");
        do_wren();
        do_prog(19'h00000, "R8 locked");
        // R11 chip erase skipped at level 7
        do_erase(C_CHIP, 19'h0, "R11 level7 skip");
        pulse(C_WRDI); m_wen = 0;

        // R11 chip erase at level 0 and level 3
        do_wren(); do_wrsr(8'h00, "R11 setup0");
        do_wren(); do_erase(C_CHIP, 19'h0, "R11 chip level0");
        do_wren(); do_wrsr(8'h0C, "R11 setup3");
        do_wren(); do_erase(C_CHIP, 19'h0, "R11 chip level3");
        // R10 block erase partially locked block skipped, lower block accepted
        do_wren(); do_erase(C_BLK, 19'h7ABCD, "R10 partial lock skip");
        do_erase(C_BLK, 19'h6ABCD, "R10 block");
        // R9 sector at lock boundary
        do_wren(); do_erase(C_SEC, 19'h78123, "R9 locked sector");
        do_erase(C_SEC, 19'h77FFF, "R9 sector below lock");

        // R12 commands dropped while busy
        do_wren();
        addr = 19'h01000;
        pulse(C_SEC);
        check(busy, "R12 busy start", busy, 1);
        pulse(C_WREN);
        pulse(C_BLK);
        check(!erase_go, "R12 no second go", erase_go, 0);
        count_busy(n);
        m_wen = 0;
        check(status == 8'h0C, "R12 wen not set", status, 8'h0C);
        // R12 strobes dropped while status write armed
        do_wren();
        cs_n = 0; din = 8'h00;
        pulse(C_WRSR);
        pulse(C_WRDI);
        cs_n = 1; @(negedge clk);
        count_busy(n);
        check(n == SR_CYC, "R12 wrdi dropped while armed", n, SR_CYC);
        m_bp = '0; m_wen = 0;

        // Random mix: R6 R7 R9 R10
        for (int it = 0; it < 30; it++) begin
            int lvl;
            lvl = $urandom_range(0, 7);
            do_wren();
            do_wrsr({1'b0, 2'($urandom), 3'(lvl), 2'b00}, "R6 rnd level");
            do_wren();
            for (int k = 0; k < 4; k++) begin
                logic [AW-1:0] a;
                a = ($urandom % 2) ? 19'($urandom) : 19'h7FFFF - 19'($urandom % 32'h20000);
                addr = a;
                @(negedge clk);
                check(wr_allow == m_locked(lvl, a) ^ 1'b1, "R6 R7 rnd allow",
                      wr_allow, !m_locked(lvl, a));
            end
            case ($urandom % 3)
                0: do_erase(C_SEC, 19'($urandom), "R9 rnd sector");
                1: do_erase(C_BLK, 19'($urandom), "R10 rnd block");
                default: do_prog(19'($urandom), "R8 rnd program");
            endcase
            if (m_wen) begin pulse(C_WRDI); m_wen = 0; end
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule